// File: doc/BRIEF.md
# Interrupt Cause and Mask Register with Event Counters

This block is one 16-bit host register of a network controller. It gathers four interrupt causes: wrap-around of a missed-frame counter, wrap-around of a receive-collision counter, the start of a frame transmission, and a user interrupt that the host raises itself. Each cause sets a sticky status flag. The host clears a flag by writing a one to its bit. Three of the causes have a mask bit. A flag whose mask is clear, together with a global enable input, drives a registered interrupt line.

The two event counters live inside the block. Each one counts single-cycle strobes and flags its overflow when it rolls from all ones to zero. The host triggers a user interrupt through a command bit. That bit hands off to the user status flag one cycle later and then clears itself. A hard reset (asynchronous, active low) and a soft reset (synchronous) return the block to its initial state. A synchronous STOP strobe wipes the pending causes but keeps the masks and the counter values.

Top module: `irq_status_mask`

## Requirements
- R1: After hard or soft reset, both counters and every status and command bit are 0. The mask bits 8, 4 and 2 are 1, so rdData reads 0x0114, and intOut is 0.
- R2: Writing 1 to a status bit clears it on the next cycle: bit 9 (missed-frame overflow), bit 6 (user interrupt), bit 5 (collision overflow) or bit 3 (transmit start). Writing 0 to it leaves it unchanged.
- R3: The mask bits (8 masks bit 9, 4 masks bit 5, 2 masks bit 3) take the written value on every host write, and the new value reads back on the next cycle.
- R4: Each counter increments by one on each cycle its event strobe is high and wraps from all ones to zero.
- R5: The event that wraps the missed-frame counter sets bit 9 on the next cycle. The event that wraps the collision counter sets bit 5 on the next cycle.
- R6: A transmit-start strobe sets bit 3 on the next cycle.
- R7: Writing 1 to bit 7 makes bit 7 read 1 on the next cycle. On the cycle after that, bit 6 reads 1 and bit 7 reads 0.
- R8: When a hardware set and a host write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R9: stopSet clears every status bit and the command bit on the next cycle, and this overrides any same-cycle set. The masks and counters are not affected by it.
- R10: intOut is 1 in the cycle after a cycle in which intEnable was 1 and at least one of these held: bit 9 set with bit 8 clear, bit 5 set with bit 4 clear, bit 3 set with bit 2 clear, or bit 6 set. Otherwise intOut is 0.
- R11: Bits 15:10 and 1:0 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, asynchronous, active low |
| softRst | input | 1 | Soft reset, synchronous |
| stopSet | input | 1 | STOP strobe that clears pending causes |
| intEnable | input | 1 | Global interrupt enable |
| missEvt | input | 1 | Missed-frame event strobe |
| collEvt | input | 1 | Receive-collision event strobe |
| txStartEvt | input | 1 | Frame transmission start strobe |
| wrEn | input | 1 | Host write enable |
| wrData | input | 16 | Host write data |
| rdData | output | 16 | Combinational register read value |
| intOut | output | 1 | Registered interrupt line |
| missCount | output | CNT_W | Missed-frame counter value |
| collCount | output | CNT_W | Receive-collision counter value |

## Verification
On every cycle, the assertions check the following:
- reserved bits read zero;
- the interrupt line is never high unless the enable was high the cycle before;
- masks read back as 1 after a soft reset;
- STOP wipes all causes;
- a transmit-start strobe is never lost to a same-cycle clear;
- the command bit self-clears and hands off to the user flag.

Counter wrap timing, mask write-back and the full mapping from flags and masks to the interrupt line can only be shown by the bench's scenarios. The bench sweeps every mask combination under both enable values, with all causes set and then cleared one at a time, on a narrow counter width.

// File: rtl/irq_reg_pkg.sv
package irq_reg_pkg;
  localparam int REG_W    = 16;
  localparam int B_MF_OVF = 9;
  localparam int B_MF_MSK = 8;
  localparam int B_UCMD   = 7;
  localparam int B_USTAT  = 6;
  localparam int B_CO_OVF = 5;
  localparam int B_CO_MSK = 4;
  localparam int B_TX     = 3;
  localparam int B_TX_MSK = 2;

  // strobes decoded by control for the datapath; maskVal order {mf, coll, tx}
  typedef struct packed {
    logic       rstAll;
    logic       stopClr;
    logic       maskWr;
    logic [2:0] maskVal;
    logic       clrMf;
    logic       clrColl;
    logic       clrTx;
    logic       clrUser;
    logic       cmdSet;
  } hostStrobe_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = evt & (&cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    cnt <= '0;
    else if (clr) cnt <= '0;
    else if (evt) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_reg_pkg::*;
(
  input  logic             softRst,
  input  logic             stopSet,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output hostStrobe_t      strb
);
  always_comb begin
    strb         = '0;
    strb.rstAll  = softRst;
    strb.stopClr = stopSet;
    strb.maskWr  = wrEn;
    strb.maskVal = {wrData[B_MF_MSK], wrData[B_CO_MSK], wrData[B_TX_MSK]};
    strb.clrMf   = wrEn & wrData[B_MF_OVF];
    strb.clrColl = wrEn & wrData[B_CO_OVF];
    strb.clrTx   = wrEn & wrData[B_TX];
    strb.clrUser = wrEn & wrData[B_USTAT];
    strb.cmdSet  = wrEn & wrData[B_UCMD];
  end
endmodule

// File: rtl/irq_reg_dp.sv
module irq_reg_dp
  import irq_reg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  hostStrobe_t      strb,
  input  logic             intEnable,
  input  logic             missEvt,
  input  logic             collEvt,
  input  logic             txStartEvt,
  output logic [REG_W-1:0] rdData,
  output logic             intOut,
  output logic [CNT_W-1:0] missCount,
  output logic [CNT_W-1:0] collCount
);
  logic missWrap, collWrap;
  logic mfOvf, coOvf, txStat, uStat, uCmd;
  logic [2:0] masks;   // {mf, coll, tx}
  logic anyCause;

  evt_counter #(.CNT_W(CNT_W)) u_missCnt (
    .clk(clk), .rstN(rstN), .clr(strb.rstAll), .evt(missEvt),
    .cnt(missCount), .wrap(missWrap));

  evt_counter #(.CNT_W(CNT_W)) u_collCnt (
    .clk(clk), .rstN(rstN), .clr(strb.rstAll), .evt(collEvt),
    .cnt(collCount), .wrap(collWrap));

  // sticky flag update: stop beats set, set beats host clear
  function automatic logic nextFlag(logic cur, logic stop, logic set, logic clr);
    if (stop)     return 1'b0;
    else if (set) return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  assign anyCause = (mfOvf & ~masks[2]) | (coOvf & ~masks[1]) |
                    (txStat & ~masks[0]) | uStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {mfOvf, coOvf, txStat, uStat, uCmd} <= '0;
      masks  <= 3'b111;
      intOut <= 1'b0;
    end else if (strb.rstAll) begin
      {mfOvf, coOvf, txStat, uStat, uCmd} <= '0;
      masks  <= 3'b111;
      intOut <= 1'b0;
    end else begin
      mfOvf  <= nextFlag(mfOvf,  strb.stopClr, missWrap,   strb.clrMf);
      coOvf  <= nextFlag(coOvf,  strb.stopClr, collWrap,   strb.clrColl);
      txStat <= nextFlag(txStat, strb.stopClr, txStartEvt, strb.clrTx);
      uStat  <= nextFlag(uStat,  strb.stopClr, uCmd,       strb.clrUser);
      uCmd   <= strb.cmdSet & ~uCmd & ~strb.stopClr;
      if (strb.maskWr) masks <= strb.maskVal;
      intOut <= intEnable & anyCause;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[B_MF_OVF] = mfOvf;
    rdData[B_MF_MSK] = masks[2];
    rdData[B_UCMD]   = uCmd;
    rdData[B_USTAT]  = uStat;
    rdData[B_CO_OVF] = coOvf;
    rdData[B_CO_MSK] = masks[1];
    rdData[B_TX]     = txStat;
    rdData[B_TX_MSK] = masks[0];
  end
endmodule

// File: rtl/irq_status_mask.sv
module irq_status_mask
  import irq_reg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             stopSet,
  input  logic             intEnable,
  input  logic             missEvt,
  input  logic             collEvt,
  input  logic             txStartEvt,
  input  logic             wrEn,
  input  logic [15:0]      wrData,
  output logic [15:0]      rdData,
  output logic             intOut,
  output logic [CNT_W-1:0] missCount,
  output logic [CNT_W-1:0] collCount
);
  hostStrobe_t strb;

  irq_reg_ctrl u_ctrl (
    .softRst(softRst), .stopSet(stopSet), .wrEn(wrEn), .wrData(wrData), .strb(strb));

  irq_reg_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .intEnable(intEnable),
    .missEvt(missEvt), .collEvt(collEvt), .txStartEvt(txStartEvt),
    .rdData(rdData), .intOut(intOut), .missCount(missCount), .collCount(collCount));
endmodule

// File: rtl/irq_status_mask_chk.sv
module irq_status_mask_chk (
  input logic        clk,
  input logic        rstN,
  input logic        softRst,
  input logic        stopSet,
  input logic        txStartEvt,
  input logic        intEnable,
  input logic [15:0] rdData,
  input logic        intOut
);
  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15:10] == 6'd0) && (rdData[1:0] == 2'd0));

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> $past(intEnable));

  assert_masks_after_soft_R1: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (rdData[8] && rdData[4] && rdData[2] && !intOut));

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stopSet && !softRst) |=> (rdData[9] == 1'b0 && rdData[7:5] == 3'b000 && rdData[3] == 1'b0));

  assert_tx_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txStartEvt && !stopSet && !softRst) |=> rdData[3]);

  assert_cmd_self_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7] |=> !rdData[7]);

  assert_cmd_handoff_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && !stopSet && !softRst) |=> rdData[6]);
endmodule

bind irq_status_mask irq_status_mask_chk u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .stopSet(stopSet),
  .txStartEvt(txStartEvt), .intEnable(intEnable), .rdData(rdData), .intOut(intOut));

// File: tb/irq_status_mask_tb.sv
module irq_status_mask_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic clk = 1'b0, rstN = 1'b0, softRst = 1'b0, stopSet = 1'b0, intEnable = 1'b0;
  logic missEvt = 1'b0, collEvt = 1'b0, txStartEvt = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic intOut;
  logic [CW-1:0] missCount, collCount;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic mf, co, tx, us, cmd, mM, cM, tM, irq;
  logic [CW-1:0] mC, cC;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_mask #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .stopSet(stopSet), .intEnable(intEnable),
    .missEvt(missEvt), .collEvt(collEvt), .txStartEvt(txStartEvt), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .intOut(intOut), .missCount(missCount),
    .collCount(collCount));

  function automatic logic [15:0] expReg();
    return {6'd0, mf, mM, cmd, us, co, cM, tx, tM, 2'b00};
  endfunction

  task automatic modelReset();
    {mf, co, tx, us, cmd, irq} = '0;
    {mM, cM, tM} = 3'b111;
    mC = '0; cC = '0;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (rdData !== expReg() || intOut !== irq || missCount !== mC || collCount !== cC) begin
      fails++;
      $display("FAIL %s: rd=%h irq=%b mc=%0d cc=%0d expected rd=%h irq=%b mc=%0d cc=%0d",
               tag, rdData, intOut, missCount, collCount, expReg(), irq, mC, cC);
    end
  endtask

  // one clock: model advances from pre-edge inputs, strobes drop, outputs compared
  task automatic step(input string tag);
    logic mW, cW, nIrq;
    @(posedge clk);
    if (softRst) modelReset();
    else begin
      mW = missEvt && (mC == '1);
      cW = collEvt && (cC == '1);
      nIrq = intEnable && ((mf && !mM) || (co && !cM) || (tx && !tM) || us);
      mC = mC + CW'(missEvt);
      cC = cC + CW'(collEvt);
      mf = stopSet ? 1'b0 : mW ? 1'b1 : (wrEn && wrData[9]) ? 1'b0 : mf;
      co = stopSet ? 1'b0 : cW ? 1'b1 : (wrEn && wrData[5]) ? 1'b0 : co;
      tx = stopSet ? 1'b0 : txStartEvt ? 1'b1 : (wrEn && wrData[3]) ? 1'b0 : tx;
      us = stopSet ? 1'b0 : cmd ? 1'b1 : (wrEn && wrData[6]) ? 1'b0 : us;
      cmd = !stopSet && !cmd && wrEn && wrData[7];
      if (wrEn) {mM, cM, tM} = {wrData[8], wrData[4], wrData[2]};
      irq = nIrq;
    end
    @(negedge clk);
    {softRst, stopSet, missEvt, collEvt, txStartEvt, wrEn} = '0;
    wrData = '0;
    compare(tag);
  endtask

  task automatic hostWrite(input logic [15:0] d, input string tag);
    wrEn = 1'b1; wrData = d;
    step(tag);
  endtask

  initial begin
    modelReset();
    repeat (2) @(negedge clk);
    compare("R1 hard reset");
    rstN = 1'b1;
    step("R1 after hard reset");

    // sweep all mask combos under both enable values
    for (int en = 0; en < 2; en++) begin
      for (int m = 0; m < 8; m++) begin
        intEnable = en[0];
        softRst = 1'b1; step("R1 soft reset");
        hostWrite({7'd0, m[2], 3'd0, m[1], 1'b0, m[0], 2'b00}, "R3 mask write");
        for (int k = 0; k < 16; k++) begin
          missEvt = 1'b1; collEvt = (k > 2);
          step("R4 count");
        end
        for (int k = 0; k < 3; k++) begin
          collEvt = 1'b1; step("R5 collision wrap");
        end
        txStartEvt = 1'b1; step("R6 tx start");
        hostWrite(16'h0000 | (16'(m[2]) << 8) | (16'(m[1]) << 4) | (16'(m[0]) << 2) | 16'h0080,
                  "R7 user cmd");
        step("R7 handoff");
        step("R10 irq settle");
        hostWrite(16'h0000 | (16'(m[2]) << 8) | (16'(m[1]) << 4) | (16'(m[0]) << 2),
                  "R2 write zero no effect");
        hostWrite({7'd0, m[2], 3'd0, m[1], 1'b0, m[0], 2'b00} | 16'h0200, "R2 clear mf");
        hostWrite({7'd0, m[2], 3'd0, m[1], 1'b0, m[0], 2'b00} | 16'h0020, "R2 clear coll");
        hostWrite({7'd0, m[2], 3'd0, m[1], 1'b0, m[0], 2'b00} | 16'h0008, "R2 clear tx");
        hostWrite({7'd0, m[2], 3'd0, m[1], 1'b0, m[0], 2'b00} | 16'h0040, "R2 clear user");
        step("R10 irq drop");
      end
    end

    // set beats same-cycle clear
    intEnable = 1'b1;
    txStartEvt = 1'b1; wrEn = 1'b1; wrData = 16'h0008; step("R8 tx set vs clear");
    for (int k = 0; k < 15; k++) begin missEvt = 1'b1; step("R4 count"); end
    missEvt = 1'b1; wrEn = 1'b1; wrData = 16'h0200; step("R8 wrap vs clear");

    // stop clears causes, keeps masks and counters, beats set
    hostWrite(16'h0080, "R3 masks zero and cmd");
    stopSet = 1'b1; txStartEvt = 1'b1; collEvt = 1'b1; step("R9 stop beats set");
    step("R9 idle after stop");
    txStartEvt = 1'b1; step("R6 tx after stop");
    stopSet = 1'b1; wrEn = 1'b1; wrData = 16'h0114; step("R9 stop with mask write");

    // reserved bits
    hostWrite(16'hFFFF, "R11 all ones write");
    step("R11 follow");
    step("R11 follow2");
    hostWrite(16'hFC03, "R11 reserved only write");
    step("R10 final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule